// File: doc/BRIEF.md
# Pull-Based Message-Passing Network Interface Controller

This controller links processing modules that share a bus. The sender never pushes the payload. The local CPU first builds a datagram in its own memory. It then issues a send request that gives the destination IP address, the bus address of the buffer and the length in bytes. The controller looks up the destination IP in a programmable table to find the bus base address of the destination module. It queues the request and, when the request reaches the head of the queue, posts a short notice that carries only the buffer address and the size. The sender keeps the buffer until the receiver acknowledges. When the acknowledgement arrives, a send interrupt tells the CPU that it may release the buffer. If no acknowledgement arrives within a programmable number of cycles, a sticky error bit is set instead.

On the receive side the controller accepts one notice at a time and fetches the remote buffer with DMA read bursts of bounded length. It writes each word into the local buffer, indexed from zero. When the last word is written it raises a receive interrupt and, in the same cycle, sends an acknowledgement back to the sender. The bus itself is abstract: a burst read port with request, grant and data beats, a local write port, and single-cycle notice and acknowledgement pulses.

Top module: `msg_nic`

## Requirements
- R1: After reset, `req_ready` and `ntc_in_ready` are 1, and `ntc_out_valid`, `rd_req`, `wr_valid`, `irq_sent`, `irq_err`, `irq_rx`, `ack_out_valid` and `err_timeout` are 0.
- R2: A send request whose IP address hits the mapping table is queued. Queued requests are posted in arrival order as one-cycle `ntc_out_valid` pulses. Each pulse carries the mapped base on `ntc_out_dest`, and the request's buffer address and size unchanged on `ntc_out_addr` and `ntc_out_size`.
- R3: A send request whose IP address matches no enabled table entry is consumed without queuing and without a notice. `irq_err` is 1 in the cycle after the handshake. A hit gives `irq_err` 0 in that cycle.
- R4: The request queue holds QDEPTH (default 4) entries that have not yet been posted. `req_ready` is 0 while the queue is full, whether or not a transfer is waiting for an acknowledgement.
- R5: At most one posted notice awaits an acknowledgement. No new notice is posted until the acknowledgement for the current one arrives or its timeout expires.
- R6: An `ack_in_valid` pulse while a notice is outstanding makes `irq_sent` 1 for exactly the next cycle. An `ack_in_valid` pulse when nothing is outstanding has no effect.
- R7: If no acknowledgement arrives within `tmo_limit` cycles, counted from the cycle the notice is visible, `err_timeout` becomes 1. It stays 1 until reset, and the next queued request is then posted.
- R8: An accepted incoming notice of S bytes is fetched as ceil(S/4) 32-bit words. The reads are issued as bursts with contiguous ascending byte addresses starting at `ntc_in_addr`. Each burst has length min(remaining words, BURST_MAX) with BURST_MAX = 16, and request, address and length are held until granted. `ntc_in_ready` is 0 while a fetch is active.
- R9: Each read data beat produces one `wr_valid` cycle with the same data. `wr_idx` counts up from 0 for each received message.
- R10: After the last word of a message is written, `irq_rx` and `ack_out_valid` are both 1 for exactly one cycle, and then `ntc_in_ready` returns to 1.
- R11: A notice of size 0 issues no read and completes with `irq_rx` and `ack_out_valid`.
- R12: When several enabled table entries hold the same IP address, the one with the lowest index supplies the base. Rewriting an entry takes effect for later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Send request present |
| req_ready | output | 1 | Request queue can take a request |
| req_ip | input | IP_W | Destination IP address |
| req_buf | input | ADDR_W | Bus address of the local message buffer |
| req_size | input | SIZE_W | Datagram size in bytes |
| map_we | input | 1 | Write one mapping table entry |
| map_idx | input | MAP_IW | Entry index to write |
| map_en | input | 1 | Enable bit written to the entry |
| map_ip | input | IP_W | IP address written to the entry |
| map_base | input | ADDR_W | Destination bus base written to the entry |
| tmo_limit | input | TMO_W | Acknowledgement timeout in cycles |
| ntc_out_valid | output | 1 | Outgoing notice pulse |
| ntc_out_dest | output | ADDR_W | Bus base of the destination module |
| ntc_out_addr | output | ADDR_W | Source buffer bus address |
| ntc_out_size | output | SIZE_W | Datagram size in bytes |
| ack_in_valid | input | 1 | Acknowledgement from the receiver |
| irq_sent | output | 1 | Buffer-release interrupt pulse |
| irq_err | output | 1 | Unmapped-destination interrupt pulse |
| err_timeout | output | 1 | Sticky acknowledgement-timeout status |
| ntc_in_valid | input | 1 | Incoming notice |
| ntc_in_ready | output | 1 | Receiver idle and able to take a notice |
| ntc_in_addr | input | ADDR_W | Remote buffer bus address |
| ntc_in_size | input | SIZE_W | Remote datagram size in bytes |
| rd_req | output | 1 | Burst read request |
| rd_gnt | input | 1 | Burst read granted |
| rd_addr | output | ADDR_W | Burst start byte address |
| rd_len | output | LEN_W | Burst length in words |
| rd_rvalid | input | 1 | Read data beat |
| rd_rdata | input | DATA_W | Read data |
| wr_valid | output | 1 | Local buffer write |
| wr_idx | output | SIZE_W | Word index in the local buffer |
| wr_data | output | DATA_W | Word written |
| irq_rx | output | 1 | Message-received interrupt pulse |
| ack_out_valid | output | 1 | Acknowledgement to the sender |

## Verification
The send path is tried with random requests to hitting, duplicate, disabled and unknown IP addresses. This shows whether the lookup priority, the error path and the notice fields are correct, and whether order is kept across misses. Directed runs then hold the acknowledgement back. This separates the queue-full back-pressure from the single-outstanding rule, and an acknowledgement that never arrives shows the timeout and the recovery afterwards. The receive path is driven with sizes of zero, one byte, exactly one burst, one word past a burst, several full bursts and random lengths, under random grant delays and gaps between data beats. These separate the round-up of the word count, the splitting into bursts, the address stepping and the completion pulse.

// File: rtl/nic_pkg.sv
package nic_pkg;
   typedef enum logic [0:0] {TX_IDLE, TX_WAIT} tx_state_e;
   typedef enum logic [1:0] {RX_IDLE, RX_REQ, RX_DATA, RX_DONE} rx_state_e;
endpackage

// File: rtl/nic_req_fifo.sv
module nic_req_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 4,
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             full,
   output logic             empty
);
   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wp, rp, wp_n, rp_n;
   logic [AW:0]      cnt;
   logic             do_push, do_pop;

   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign full    = (cnt == (AW+1)'(DEPTH));
   assign empty   = (cnt == '0);
   assign rdata   = mem[rp];

   // pointer wrap: free-running for power-of-two depth, compare otherwise
   if (DEPTH == (1 << AW)) begin : g_pow2
      assign wp_n = wp + 1'b1;
      assign rp_n = rp + 1'b1;
   end else begin : g_wrap
      assign wp_n = (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      assign rp_n = (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp_n;
         if (do_pop)  rp <= rp_n;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end
endmodule

// File: rtl/nic_map_table.sv
module nic_map_table #(
   parameter int ENTRIES = 4,
   parameter int IP_W    = 32,
   parameter int ADDR_W  = 32,
   localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IW-1:0]     wr_idx,
   input  logic              wr_valid,
   input  logic [IP_W-1:0]   wr_ip,
   input  logic [ADDR_W-1:0] wr_base,
   input  logic [IP_W-1:0]   look_ip,
   output logic              hit,
   output logic [ADDR_W-1:0] base
);
   logic [ENTRIES-1:0]             match;
   logic [ENTRIES-1:0][ADDR_W-1:0] base_v;

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic              en_q;
      logic [IP_W-1:0]   ip_q;
      logic [ADDR_W-1:0] base_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            en_q   <= 1'b0;
            ip_q   <= '0;
            base_q <= '0;
         end else if (wr_en && wr_idx == IW'(i)) begin
            en_q   <= wr_valid;
            ip_q   <= wr_ip;
            base_q <= wr_base;
         end
      end

      assign match[i]  = en_q && (ip_q == look_ip);
      assign base_v[i] = base_q;
   end

   // lowest matching index wins
   always_comb begin
      hit  = |match;
      base = '0;
      for (int i = ENTRIES-1; i >= 0; i--) begin
         if (match[i]) base = base_v[i];
      end
   end
endmodule

// File: rtl/nic_tx_seq.sv
module nic_tx_seq
   import nic_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 16,
   parameter int TMO_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              q_empty,
   input  logic [ADDR_W-1:0] q_dest,
   input  logic [ADDR_W-1:0] q_buf,
   input  logic [SIZE_W-1:0] q_size,
   output logic              q_pop,
   input  logic              ack_in,
   input  logic [TMO_W-1:0]  tmo_limit,
   output logic              ntc_valid,
   output logic [ADDR_W-1:0] ntc_dest,
   output logic [ADDR_W-1:0] ntc_addr,
   output logic [SIZE_W-1:0] ntc_size,
   output logic              irq_sent,
   output logic              err_tmo
);
   tx_state_e        state;
   logic [TMO_W-1:0] wait_cnt;

   assign q_pop = (state == TX_IDLE) && !q_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= TX_IDLE;
         wait_cnt  <= '0;
         ntc_valid <= 1'b0;
         ntc_dest  <= '0;
         ntc_addr  <= '0;
         ntc_size  <= '0;
         irq_sent  <= 1'b0;
         err_tmo   <= 1'b0;
      end else begin
         ntc_valid <= 1'b0;
         irq_sent  <= 1'b0;
         case (state)
            TX_IDLE: begin
               if (!q_empty) begin
                  ntc_valid <= 1'b1;
                  ntc_dest  <= q_dest;
                  ntc_addr  <= q_buf;
                  ntc_size  <= q_size;
                  wait_cnt  <= TMO_W'(1);
                  state     <= TX_WAIT;
               end
            end
            TX_WAIT: begin
               if (ack_in) begin
                  irq_sent <= 1'b1;
                  state    <= TX_IDLE;
               end else if (wait_cnt >= tmo_limit) begin
                  err_tmo <= 1'b1;
                  state   <= TX_IDLE;
               end else begin
                  wait_cnt <= wait_cnt + 1'b1;
               end
            end
            default: state <= TX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/nic_rx_dma.sv
module nic_rx_dma
   import nic_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int SIZE_W    = 16,
   parameter int BURST_MAX = 16,
   localparam int LEN_W    = $clog2(BURST_MAX + 1),
   localparam int BYTES    = DATA_W / 8,
   localparam int SH       = $clog2(BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ntc_valid,
   input  logic [ADDR_W-1:0] ntc_addr,
   input  logic [SIZE_W-1:0] ntc_size,
   output logic              ntc_ready,
   output logic              rd_req,
   input  logic              rd_gnt,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [LEN_W-1:0]  rd_len,
   input  logic              rd_rvalid,
   input  logic [DATA_W-1:0] rd_rdata,
   output logic              wr_valid,
   output logic [SIZE_W-1:0] wr_idx,
   output logic [DATA_W-1:0] wr_data,
   output logic              irq_rx,
   output logic              ack_out
);
   localparam logic [SIZE_W-1:0] PART_MASK = SIZE_W'(BYTES - 1);

   rx_state_e         state;
   logic [ADDR_W-1:0] addr_q;
   logic [SIZE_W-1:0] rem, widx, words;
   logic [LEN_W-1:0]  beats, burst_len;

   // whole words, a trailing partial word rounds up
   assign words = (ntc_size >> SH) + SIZE_W'(|(ntc_size & PART_MASK));

   always_comb begin
      if (rem > SIZE_W'(BURST_MAX)) burst_len = LEN_W'(BURST_MAX);
      else                          burst_len = LEN_W'(rem);
   end

   assign ntc_ready = (state == RX_IDLE);
   assign rd_req    = (state == RX_REQ);
   assign rd_addr   = addr_q;
   assign rd_len    = burst_len;
   assign irq_rx    = (state == RX_DONE);
   assign ack_out   = (state == RX_DONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RX_IDLE;
         addr_q   <= '0;
         rem      <= '0;
         widx     <= '0;
         beats    <= '0;
         wr_valid <= 1'b0;
         wr_idx   <= '0;
         wr_data  <= '0;
      end else begin
         wr_valid <= 1'b0;
         case (state)
            RX_IDLE: begin
               if (ntc_valid) begin
                  addr_q <= ntc_addr;
                  rem    <= words;
                  widx   <= '0;
                  state  <= (words == '0) ? RX_DONE : RX_REQ;
               end
            end
            RX_REQ: begin
               if (rd_gnt) begin
                  beats <= burst_len;
                  state <= RX_DATA;
               end
            end
            RX_DATA: begin
               if (rd_rvalid) begin
                  wr_valid <= 1'b1;
                  wr_data  <= rd_rdata;
                  wr_idx   <= widx;
                  widx     <= widx + 1'b1;
                  rem      <= rem - 1'b1;
                  beats    <= beats - 1'b1;
                  addr_q   <= addr_q + ADDR_W'(BYTES);
                  if (beats == LEN_W'(1)) begin
                     state <= (rem == SIZE_W'(1)) ? RX_DONE : RX_REQ;
                  end
               end
            end
            RX_DONE: state <= RX_IDLE;
            default: state <= RX_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/msg_nic.sv
module msg_nic #(
   parameter int IP_W        = 32,
   parameter int ADDR_W      = 32,
   parameter int DATA_W      = 32,
   parameter int SIZE_W      = 16,
   parameter int QDEPTH      = 4,
   parameter int MAP_ENTRIES = 4,
   parameter int BURST_MAX   = 16,
   parameter int TMO_W       = 16,
   localparam int MAP_IW     = (MAP_ENTRIES > 1) ? $clog2(MAP_ENTRIES) : 1,
   localparam int LEN_W      = $clog2(BURST_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [IP_W-1:0]   req_ip,
   input  logic [ADDR_W-1:0] req_buf,
   input  logic [SIZE_W-1:0] req_size,
   input  logic              map_we,
   input  logic [MAP_IW-1:0] map_idx,
   input  logic              map_en,
   input  logic [IP_W-1:0]   map_ip,
   input  logic [ADDR_W-1:0] map_base,
   input  logic [TMO_W-1:0]  tmo_limit,
   output logic              ntc_out_valid,
   output logic [ADDR_W-1:0] ntc_out_dest,
   output logic [ADDR_W-1:0] ntc_out_addr,
   output logic [SIZE_W-1:0] ntc_out_size,
   input  logic              ack_in_valid,
   output logic              irq_sent,
   output logic              irq_err,
   output logic              err_timeout,
   input  logic              ntc_in_valid,
   output logic              ntc_in_ready,
   input  logic [ADDR_W-1:0] ntc_in_addr,
   input  logic [SIZE_W-1:0] ntc_in_size,
   output logic              rd_req,
   input  logic              rd_gnt,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [LEN_W-1:0]  rd_len,
   input  logic              rd_rvalid,
   input  logic [DATA_W-1:0] rd_rdata,
   output logic              wr_valid,
   output logic [SIZE_W-1:0] wr_idx,
   output logic [DATA_W-1:0] wr_data,
   output logic              irq_rx,
   output logic              ack_out_valid
);
   localparam int ENTRY_W = 2 * ADDR_W + SIZE_W;

   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data
      $error("msg_nic: DATA_W must be a whole number of bytes");
   end
   if ((DATA_W / 8) & ((DATA_W / 8) - 1)) begin : g_bad_bytes
      $error("msg_nic: DATA_W/8 must be a power of two");
   end
   if (QDEPTH < 1 || MAP_ENTRIES < 1 || BURST_MAX < 1 || TMO_W < 1) begin : g_bad_count
      $error("msg_nic: depths, entry count, burst and timeout width must be positive");
   end

   logic               map_hit, q_full, q_empty, q_pop, q_push;
   logic [ADDR_W-1:0]  map_dest, q_dest, q_buf;
   logic [SIZE_W-1:0]  q_size;
   logic [ENTRY_W-1:0] q_rdata;

   nic_map_table #(
      .ENTRIES(MAP_ENTRIES), .IP_W(IP_W), .ADDR_W(ADDR_W)
   ) i_map (
      .clk(clk), .rst_n(rst_n),
      .wr_en(map_we), .wr_idx(map_idx), .wr_valid(map_en),
      .wr_ip(map_ip), .wr_base(map_base),
      .look_ip(req_ip), .hit(map_hit), .base(map_dest)
   );

   assign req_ready = !q_full;
   assign q_push    = req_valid && req_ready && map_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_err <= 1'b0;
      else        irq_err <= req_valid && req_ready && !map_hit;
   end

   nic_req_fifo #(.WIDTH(ENTRY_W), .DEPTH(QDEPTH)) i_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(q_push), .wdata({map_dest, req_buf, req_size}),
      .pop(q_pop), .rdata(q_rdata),
      .full(q_full), .empty(q_empty)
   );

   assign {q_dest, q_buf, q_size} = q_rdata;

   nic_tx_seq #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .TMO_W(TMO_W)) i_tx (
      .clk(clk), .rst_n(rst_n),
      .q_empty(q_empty), .q_dest(q_dest), .q_buf(q_buf), .q_size(q_size),
      .q_pop(q_pop), .ack_in(ack_in_valid), .tmo_limit(tmo_limit),
      .ntc_valid(ntc_out_valid), .ntc_dest(ntc_out_dest),
      .ntc_addr(ntc_out_addr), .ntc_size(ntc_out_size),
      .irq_sent(irq_sent), .err_tmo(err_timeout)
   );

   nic_rx_dma #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIZE_W(SIZE_W), .BURST_MAX(BURST_MAX)
   ) i_rx (
      .clk(clk), .rst_n(rst_n),
      .ntc_valid(ntc_in_valid), .ntc_addr(ntc_in_addr), .ntc_size(ntc_in_size),
      .ntc_ready(ntc_in_ready),
      .rd_req(rd_req), .rd_gnt(rd_gnt), .rd_addr(rd_addr), .rd_len(rd_len),
      .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
      .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data),
      .irq_rx(irq_rx), .ack_out(ack_out_valid)
   );
endmodule

// File: rtl/nic_msg_chk.sv
module nic_msg_chk #(
   parameter int ADDR_W    = 32,
   parameter int BURST_MAX = 16,
   parameter int LEN_W     = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ntc_out_valid,
   input logic              irq_sent,
   input logic              err_timeout,
   input logic              ntc_in_ready,
   input logic              rd_req,
   input logic              rd_gnt,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [LEN_W-1:0]  rd_len,
   input logic              wr_valid,
   input logic              irq_rx,
   input logic              ack_out_valid
);
   // R8
   burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |-> (rd_len != '0 && rd_len <= LEN_W'(BURST_MAX)));

   // R8
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req && !rd_gnt) |=> (rd_req && $stable(rd_addr) && $stable(rd_len)));

   // R8
   rx_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req || wr_valid) |-> !ntc_in_ready);

   // R10
   rx_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rx |=> (!irq_rx && !ack_out_valid && ntc_in_ready));

   // R10
   rx_done_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rx |-> (ack_out_valid && !rd_req));

   // R7
   tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_timeout |=> err_timeout);

   // R6
   sent_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_sent |-> !ntc_out_valid);

   // R5
   notice_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ntc_out_valid |=> !ntc_out_valid);
endmodule

bind msg_nic nic_msg_chk #(.ADDR_W(ADDR_W), .BURST_MAX(BURST_MAX), .LEN_W(LEN_W)) i_chk (
   .clk(clk), .rst_n(rst_n),
   .ntc_out_valid(ntc_out_valid), .irq_sent(irq_sent), .err_timeout(err_timeout),
   .ntc_in_ready(ntc_in_ready), .rd_req(rd_req), .rd_gnt(rd_gnt),
   .rd_addr(rd_addr), .rd_len(rd_len), .wr_valid(wr_valid),
   .irq_rx(irq_rx), .ack_out_valid(ack_out_valid)
);

// File: tb/test_msg_nic.sv
module test_msg_nic;
   localparam int CLK_P = 10;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        req_valid = 0, req_ready;
   logic [31:0] req_ip = 0, req_buf = 0;
   logic [15:0] req_size = 0;
   logic        map_we = 0, map_en = 0;
   logic [1:0]  map_idx = 0;
   logic [31:0] map_ip = 0, map_base = 0;
   logic [15:0] tmo_limit = 16'd1000;
   logic        ntc_out_valid;
   logic [31:0] ntc_out_dest, ntc_out_addr;
   logic [15:0] ntc_out_size;
   logic        ack_in_valid = 0, irq_sent, irq_err, err_timeout;
   logic        ntc_in_valid = 0, ntc_in_ready;
   logic [31:0] ntc_in_addr = 0;
   logic [15:0] ntc_in_size = 0;
   logic        rd_req, rd_gnt = 0, rd_rvalid = 0;
   logic [31:0] rd_addr, rd_rdata = 0;
   logic [4:0]  rd_len;
   logic        wr_valid;
   logic [15:0] wr_idx;
   logic [31:0] wr_data;
   logic        irq_rx, ack_out_valid;

   msg_nic i_msg_nic (.*);

   always #(CLK_P/2) clk = ~clk;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   task automatic check(bit ok, string req, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [31:0] memf(logic [31:0] a);
      return {a[15:0], a[31:16]} ^ 32'hC3A5_5A3C;
   endfunction

   // bench model of the mapping table
   bit          m_en[4];
   logic [31:0] m_ip[4], m_base[4];

   function automatic bit model_hit(logic [31:0] ip, output logic [31:0] base);
      for (int i = 0; i < 4; i++) begin
         if (m_en[i] && m_ip[i] == ip) begin
            base = m_base[i];
            return 1;
         end
      end
      base = 0;
      return 0;
   endfunction

   logic [31:0] q_dest[$], q_buf[$];
   logic [15:0] q_size[$];

   // remote receiver model: checks notices and returns acknowledgements
   bit ack_en = 1, pending = 0;
   int delay = 0;
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && ntc_out_valid) begin
            check(!pending, "R5 notice while outstanding", pending, 0);
            if (q_dest.size() == 0) begin
               check(0, "R2 unexpected notice", 1, 0);
            end else begin
               logic [31:0] ed, eb;
               logic [15:0] es;
               ed = q_dest.pop_front(); eb = q_buf.pop_front(); es = q_size.pop_front();
               check(ntc_out_dest == ed, "R2 dest", ntc_out_dest, ed);
               check(ntc_out_addr == eb, "R2 addr", ntc_out_addr, eb);
               check(ntc_out_size == es, "R2 size", ntc_out_size, es);
            end
            pending = 1;
            delay = $urandom % 4;
         end else if (pending && ack_en) begin
            if (delay > 0) delay--;
            else begin
               ack_in_valid = 1;
               @(negedge clk);
               ack_in_valid = 0;
               check(irq_sent === 1'b1, "R6 irq_sent after ack", irq_sent, 1);
               pending = 0;
            end
         end
      end
   end

   // memory model on the read port
   int          rx_words = 0, rx_asked = 0, rx_bursts = 0;
   logic [31:0] next_addr = 0;
   initial begin
      forever begin
         @(negedge clk);
         rd_gnt = 0;
         rd_rvalid = 0;
         if (rst_n && rd_req && ($urandom % 3 != 0)) begin
            int          n, expl;
            logic [31:0] a;
            expl = (rx_words - rx_asked > 16) ? 16 : rx_words - rx_asked;
            check(rd_len == expl, "R8 burst length", rd_len, expl);
            check(rd_addr == next_addr, "R8 burst address", rd_addr, next_addr);
            rd_gnt = 1;
            a = rd_addr;
            n = rd_len;
            rx_asked += n;
            rx_bursts++;
            next_addr = next_addr + 32'(4 * n);
            @(negedge clk);
            rd_gnt = 0;
            for (int b = 0; b < n; b++) begin
               while ($urandom % 4 == 0) begin
                  rd_rvalid = 0;
                  @(negedge clk);
               end
               rd_rvalid = 1;
               rd_rdata = memf(a);
               a += 4;
               @(negedge clk);
            end
            rd_rvalid = 0;
         end
      end
   end

   // local write port and completion monitor
   int          rx_idx = 0, rx_done = 0;
   logic [31:0] rx_base = 0;
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && wr_valid) begin
            logic [31:0] ev;
            ev = memf(rx_base + 32'(4 * rx_idx));
            check(wr_idx == 16'(rx_idx), "R9 wr_idx", wr_idx, rx_idx);
            check(wr_data == ev, "R9 wr_data", wr_data, ev);
            rx_idx++;
         end
         if (rst_n && irq_rx) begin
            check(ack_out_valid === 1'b1, "R10 ack with irq_rx", ack_out_valid, 1);
            check(rx_idx == rx_words, "R8 word count", rx_idx, rx_words);
            rx_done++;
         end
      end
   end

   task automatic map_write(int idx, bit en, logic [31:0] ip, logic [31:0] base);
      @(negedge clk);
      map_we = 1; map_idx = 2'(idx); map_en = en; map_ip = ip; map_base = base;
      @(negedge clk);
      map_we = 0;
      m_en[idx] = en; m_ip[idx] = ip; m_base[idx] = base;
   endtask

   task automatic submit(logic [31:0] ip, logic [31:0] bufa, logic [15:0] sz);
      logic [31:0] eb;
      bit          h;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1; req_ip = ip; req_buf = bufa; req_size = sz;
      h = model_hit(ip, eb);
      if (h) begin
         q_dest.push_back(eb); q_buf.push_back(bufa); q_size.push_back(sz);
      end
      @(negedge clk);
      req_valid = 0;
      check(irq_err === !h, "R3 irq_err", irq_err, !h);
   endtask

   task automatic drain();
      for (int i = 0; i < 5000 && (q_dest.size() != 0 || pending); i++) @(negedge clk);
      check(q_dest.size() == 0 && !pending, "R2 queue drained", q_dest.size(), 0);
   endtask

   task automatic notice(logic [31:0] addr, logic [15:0] sz);
      int d0;
      @(negedge clk);
      while (!ntc_in_ready) @(negedge clk);
      d0 = rx_done;
      rx_words = (int'(sz) + 3) / 4; rx_asked = 0; rx_bursts = 0;
      rx_idx = 0; rx_base = addr; next_addr = addr;
      ntc_in_valid = 1; ntc_in_addr = addr; ntc_in_size = sz;
      @(negedge clk);
      ntc_in_valid = 0;
      if (sz != 0) check(ntc_in_ready === 1'b0, "R8 busy during fetch", ntc_in_ready, 0);
      for (int i = 0; i < 3000 && rx_done == d0; i++) @(negedge clk);
      check(rx_done == d0 + 1, "R10 completion", rx_done, d0 + 1);
      @(negedge clk);
      check(ntc_in_ready === 1'b1, "R10 ready again", ntc_in_ready, 1);
   endtask

   localparam logic [31:0] IP_A = 32'h0A00_0001, IP_B = 32'h0A00_0002,
                           IP_C = 32'h0A00_0003, IP_D = 32'h0A00_0004;

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1
      check(req_ready === 1 && ntc_in_ready === 1, "R1 ready after reset",
            {req_ready, ntc_in_ready}, 2'b11);
      check({ntc_out_valid, rd_req, wr_valid, irq_sent, irq_err, irq_rx,
             ack_out_valid, err_timeout} === 8'h00, "R1 outputs idle after reset",
            {ntc_out_valid, rd_req, wr_valid, irq_sent, irq_err, irq_rx,
             ack_out_valid, err_timeout}, 0);

      map_write(0, 1, IP_A, 32'h1000_0000);
      map_write(1, 1, IP_B, 32'h2000_0000);
      map_write(2, 1, IP_B, 32'h3000_0000);  // R12 duplicate, index 1 must win
      map_write(3, 0, IP_C, 32'h4000_0000);  // disabled entry

      submit(IP_A, 32'h0000_1000, 16'd40);
      submit(IP_B, 32'h0000_2000, 16'd7);
      submit(IP_C, 32'h0000_3000, 16'd9);   // R3 disabled entry is a miss
      submit(32'hDEAD_BEEF, 32'h0000_4000, 16'd1);
      drain();

      // R12 rewrite: B now only at index 2
      map_write(1, 1, IP_D, 32'h5000_0000);
      submit(IP_B, 32'h0000_5000, 16'd12);
      submit(IP_D, 32'h0000_6000, 16'd3);
      drain();

      // R6 stray acknowledgement with nothing outstanding
      @(negedge clk);
      ack_in_valid = 1;
      @(negedge clk);
      ack_in_valid = 0;
      check(irq_sent === 1'b0, "R6 stray ack ignored", irq_sent, 0);

      // random send traffic
      for (int i = 0; i < 30; i++) begin
         logic [31:0] ip;
         case ($urandom % 5)
            0: ip = IP_A;
            1: ip = IP_B;
            2: ip = IP_D;
            3: ip = IP_C;
            default: ip = 32'hC000_0000 | ($urandom % 256);
         endcase
         submit(ip, $urandom, 16'($urandom));
      end
      drain();

      // R4 queue full with one transfer outstanding
      ack_en = 0;
      for (int i = 0; i < 5; i++) submit(IP_A, 32'h0000_7000 + 32'(i * 64), 16'(i + 1));
      @(negedge clk);
      check(req_ready === 1'b0, "R4 ready low when full", req_ready, 0);
      repeat (3) @(negedge clk);
      check(req_ready === 1'b0, "R4 ready stays low", req_ready, 0);
      check(q_dest.size() == 4, "R5 only one posted", q_dest.size(), 4);
      ack_en = 1;
      drain();

      // R7 timeout and recovery
      check(err_timeout === 1'b0, "R7 no timeout yet", err_timeout, 0);
      tmo_limit = 16'd20;
      ack_en = 0;
      submit(IP_A, 32'h0000_8000, 16'd4);
      repeat (40) @(negedge clk);
      check(err_timeout === 1'b1, "R7 timeout set", err_timeout, 1);
      pending = 0;
      ack_en = 1;
      submit(IP_D, 32'h0000_9000, 16'd8);
      drain();
      check(err_timeout === 1'b1, "R7 timeout sticky", err_timeout, 1);

      // receive path directed sizes
      notice(32'h2000_0100, 16'd64);
      check(rx_bursts == 1, "R8 one full burst", rx_bursts, 1);
      notice(32'h2000_0400, 16'd65);
      check(rx_bursts == 2, "R8 partial word adds burst", rx_bursts, 2);
      notice(32'h2000_0800, 16'd1);
      check(rx_idx == 1, "R8 single byte rounds up", rx_idx, 1);
      notice(32'h2000_0C00, 16'd0);
      // R11
      check(rx_bursts == 0 && rx_idx == 0, "R11 empty message no reads", rx_bursts, 0);
      notice(32'h2000_1000, 16'd256);
      check(rx_bursts == 4, "R8 four bursts", rx_bursts, 4);
      for (int i = 0; i < 20; i++) notice({$urandom} & 32'hFFFF_FFFC, 16'($urandom % 300));

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(CLK_P * 150000);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule